// File: doc/BRIEF.md
# Latched Edge Interrupt Input Unit

This block takes a small group of external interrupt pins, four by default, and turns edges on them into prioritised requests for a processor core. Every pin passes through a two-flop synchroniser. An edge detector then watches for the edge direction chosen for that pin, rising or falling. A detected edge sets a sticky pending bit, so a pulse that has already gone away is still serviced. A pending request reaches the core only when its enable bit is set and its priority level is nonzero.

Among the eligible inputs the block picks the one with the highest level. On a tie the lower index wins. A small presentation state machine drives the winner's level and vector to the core. The vector of input `i` is the programmable vector base plus `i`, so each input has its own distinct vector. The core acknowledges by pulsing `ack_valid` together with the vector it is taking. This clears that input's pending bit. Software can also clear pending bits by writing ones to the pending register.

The presentation machine has three states. `S_IDLE` drives level 0 and takes the transition *request* to `S_PRESENT` when any input is eligible. `S_PRESENT` refreshes the level and vector every cycle from the arbiter. From there it takes *acknowledge* to `S_SETTLE` when `ack_valid` is high, or *withdraw* back to `S_IDLE` when nothing is eligible any more. `S_SETTLE` drives level 0 for one cycle and always takes *resume* to `S_IDLE`. This lets the cleared pending bit take effect before the arbiter is consulted again.

Top module: `irq_edge_unit`

## Requirements
- R1: Edge register (address 2) bit `i` selects the active edge of pin `i`: 1 for rising, 0 for falling. Only a transition to the selected level sets the pending bit. The pin is sampled through two synchronising flops.
- R2: An active edge sets pending bit `i` whether or not the input is enabled or has a nonzero level. A pulse of one clock width is latched.
- R3: A register write to address 0 clears each pending bit whose data bit is 1. Data bits of 0 leave pending bits unchanged.
- R4: When a clear (register write or acknowledge) and a new active edge hit the same pending bit in the same cycle, the bit stays set.
- R5: Enable register (address 1) bit `i` gates input `i`. A pending but disabled input is never presented. Enabling it later presents it.
- R6: Level register (address 3) holds a 3-bit level for input `i` at bits [3i+2:3i]. Level 0 keeps the input from ever being presented. Levels 1 to 7 are valid.
- R7: `irq_level` shows the highest level among inputs that are pending, enabled and at a nonzero level. On equal levels the lowest index wins. `irq_level` is 0 when no input is eligible.
- R8: `irq_vector` equals the vector base (address 4, bits [7:0]) plus the winner's index, modulo 256.
- R9: `ack_valid` with `ack_vector` clears the pending bit of the input whose vector matches. If a request was shown, `irq_level` reads 0 in the following cycle.
- R10: After reset: pending 0, enable 0, edge register all ones, levels 0, vector base 0, `irq_level` and `irq_vector` 0.
- R11: All five registers read back on `reg_rdata` combinationally from `reg_addr`. Unmapped addresses read 0.
- R12: Rewriting the edge register creates no event, even when the pin is held at the newly selected level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 4 | External interrupt pins, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ack_valid | input | 1 | Core acknowledge strobe |
| ack_vector | input | 8 | Vector being acknowledged |
| irq_level | output | 3 | Presented priority level, 0 for none |
| irq_vector | output | 8 | Presented vector number |

## Verification
The bench builds the block with its defaults: four inputs, 3-bit levels, 8-bit vectors and a 32-bit register port. With four inputs and levels 0 to 7, both paths are reached: a tie between two inputs at one level, and a pending input hidden by level 0. Using 8-bit vectors lets a random vector base near 255 push `irq_vector` through modulo wrap. The 32-bit register port holds the full 12-bit level field in one write, so one random write can reorder the priorities of all inputs.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_PRESENT = 2'd1,
        S_SETTLE  = 2'd2
    } pres_state_t;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] ADDR_PEND  = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_EN    = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_EDGE  = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_LEVEL = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_VBASE = 3'd4;

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] rise_sel,
    output logic [N-1:0] evt
);

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        // direction chosen after detection, so a polarity change alone never fires
        assign evt[i] = rise_sel[i] ? (sync_q & ~prev_q) : (~sync_q & prev_q);
    end

endmodule

// File: rtl/irq_pend_regs.sv
module irq_pend_regs
    import irq_edge_pkg::*;
#(
    parameter int N      = 4,
    parameter int LVL_W  = 3,
    parameter int VEC_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [N-1:0]       evt,
    input  logic               ack_valid,
    input  logic [VEC_W-1:0]   ack_vector,
    output logic [N-1:0]       pending,
    output logic [N-1:0]       enable,
    output logic [N-1:0]       rise_sel,
    output logic [N*LVL_W-1:0] levels,
    output logic [VEC_W-1:0]   vbase
);

    localparam int LVLS_W = N * LVL_W;

    logic [N-1:0] ack_hit;
    logic [N-1:0] w1c;
    logic         unused_wdata;

    assign unused_wdata = ^reg_wdata;

    for (genvar i = 0; i < N; i++) begin : g_ack
        assign ack_hit[i] = ack_valid && (ack_vector == VEC_W'(vbase + VEC_W'(i)));
    end

    assign w1c = (reg_wr && reg_addr == ADDR_PEND) ? reg_wdata[N-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending  <= '0;
            enable   <= '0;
            rise_sel <= '1;
            levels   <= '0;
            vbase    <= '0;
        end else begin
            // a fresh edge outranks any clear in the same cycle
            pending <= (pending & ~(w1c | ack_hit)) | evt;
            if (reg_wr) begin
                unique case (reg_addr)
                    ADDR_EN:    enable   <= reg_wdata[N-1:0];
                    ADDR_EDGE:  rise_sel <= reg_wdata[N-1:0];
                    ADDR_LEVEL: levels   <= reg_wdata[LVLS_W-1:0];
                    ADDR_VBASE: vbase    <= reg_wdata[VEC_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_PEND:  reg_rdata = DATA_W'(pending);
            ADDR_EN:    reg_rdata = DATA_W'(enable);
            ADDR_EDGE:  reg_rdata = DATA_W'(rise_sel);
            ADDR_LEVEL: reg_rdata = DATA_W'(levels);
            ADDR_VBASE: reg_rdata = DATA_W'(vbase);
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N     = 4,
    parameter int LVL_W = 3,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]       pending,
    input  logic [N-1:0]       enable,
    input  logic [N*LVL_W-1:0] levels,
    output logic [N-1:0]       eligible,
    output logic               any,
    output logic [IDX_W-1:0]   win_idx,
    output logic [LVL_W-1:0]   win_lvl
);

    for (genvar i = 0; i < N; i++) begin : g_elig
        assign eligible[i] = pending[i] && enable[i] && (levels[i*LVL_W +: LVL_W] != '0);
    end

    assign any = |eligible;

    // strict compare keeps the lowest index on a tie
    always_comb begin
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (eligible[i] && levels[i*LVL_W +: LVL_W] > win_lvl) begin
                win_idx = IDX_W'(i);
                win_lvl = levels[i*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/irq_present_fsm.sv
module irq_present_fsm
    import irq_edge_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any,
    input  logic [IDX_W-1:0] win_idx,
    input  logic [LVL_W-1:0] win_lvl,
    input  logic [VEC_W-1:0] vbase,
    input  logic             ack_valid,
    output logic [LVL_W-1:0] irq_level,
    output logic [VEC_W-1:0] irq_vector
);

    pres_state_t state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:    if (any) state_n = S_PRESENT;
            S_PRESENT: begin
                if (ack_valid)  state_n = S_SETTLE;
                else if (!any)  state_n = S_IDLE;
            end
            S_SETTLE:  state_n = S_IDLE;
            default:   state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_level  <= '0;
            irq_vector <= '0;
        end else if (state_n == S_PRESENT) begin
            irq_level  <= win_lvl;
            irq_vector <= VEC_W'(vbase + VEC_W'(win_idx));
        end else begin
            irq_level  <= '0;
            irq_vector <= '0;
        end
    end

endmodule

// File: rtl/irq_edge_unit.sv
module irq_edge_unit
    import irq_edge_pkg::*;
#(
    parameter int N      = 4,
    parameter int LVL_W  = 3,
    parameter int VEC_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      irq_pin,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ack_valid,
    input  logic [VEC_W-1:0]  ack_vector,
    output logic [LVL_W-1:0]  irq_level,
    output logic [VEC_W-1:0]  irq_vector
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]       evt, pending, enable, rise_sel, eligible;
    logic [N*LVL_W-1:0] levels;
    logic [VEC_W-1:0]   vbase;
    logic               any;
    logic [IDX_W-1:0]   win_idx;
    logic [LVL_W-1:0]   win_lvl;

    irq_edge_sync #(.N(N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(irq_pin), .rise_sel(rise_sel), .evt(evt)
    );

    irq_pend_regs #(.N(N), .LVL_W(LVL_W), .VEC_W(VEC_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt),
        .ack_valid(ack_valid), .ack_vector(ack_vector), .pending(pending),
        .enable(enable), .rise_sel(rise_sel), .levels(levels), .vbase(vbase)
    );

    irq_arbiter #(.N(N), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
        .pending(pending), .enable(enable), .levels(levels), .eligible(eligible),
        .any(any), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    irq_present_fsm #(.LVL_W(LVL_W), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .any(any), .win_idx(win_idx), .win_lvl(win_lvl),
        .vbase(vbase), .ack_valid(ack_valid), .irq_level(irq_level),
        .irq_vector(irq_vector)
    );

endmodule

// File: rtl/irq_edge_unit_chk.sv
module irq_edge_unit_chk
    import irq_edge_pkg::*;
#(
    parameter int N     = 4,
    parameter int LVL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [N-1:0]      wdata_lo,
    input logic              ack_valid,
    input logic [LVL_W-1:0]  irq_level,
    input logic [N-1:0]      evt,
    input logic [N-1:0]      pending,
    input logic [N-1:0]      eligible
);

    // R2
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pending & $past(evt)) == $past(evt)));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_PEND) |=>
            ((pending & $past(wdata_lo) & ~$past(evt)) == '0));

    // R4
    clear_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_PEND && (wdata_lo & evt) != '0) |=>
            ((pending & $past(wdata_lo & evt)) == $past(wdata_lo & evt)));

    // R7
    no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eligible == '0) |=> (irq_level == '0));

    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && irq_level != '0) |=> (irq_level == '0));

endmodule

bind irq_edge_unit irq_edge_unit_chk #(.N(N), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wdata_lo(reg_wdata[N-1:0]), .ack_valid(ack_valid), .irq_level(irq_level),
    .evt(evt), .pending(pending), .eligible(eligible)
);

// File: tb/irq_edge_unit_tb.sv
module irq_edge_unit_tb;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_pin = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ack_valid = 1'b0;
    logic [7:0]  ack_vector = '0;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int checks = 0;
    int failures = 0;

    logic [3:0]  m_pend = '0, m_en = '0, m_rise = 4'hF;
    logic [11:0] m_lvl = '0;
    logic [7:0]  m_vbase = '0;

    irq_edge_unit u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ack_valid(ack_valid), .ack_vector(ack_vector), .irq_level(irq_level),
        .irq_vector(irq_vector)
    );

    always #10 clk = ~clk;

    function automatic logic [2:0] exp_level();
        logic [2:0] best = '0;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && m_en[i] && m_lvl[i*3 +: 3] > best) best = m_lvl[i*3 +: 3];
        return best;
    endfunction

    function automatic logic [7:0] exp_vector();
        logic [2:0] best = '0;
        logic [7:0] v = '0;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && m_en[i] && m_lvl[i*3 +: 3] > best) begin
                best = m_lvl[i*3 +: 3];
                v = m_vbase + 8'(i);
            end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 3'd0) m_pend = m_pend & ~d[3:0];
        if (a == 3'd1) m_en = d[3:0];
        if (a == 3'd2) m_rise = d[3:0];
        if (a == 3'd3) m_lvl = d[11:0];
        if (a == 3'd4) m_vbase = d[7:0];
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic toggle(input logic [3:0] sel);
        @(negedge clk);
        irq_pin = irq_pin ^ sel;
        for (int i = 0; i < N; i++)
            if (sel[i] && irq_pin[i] == m_rise[i]) m_pend[i] = 1'b1;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic chk_out(input string tag);
        logic [31:0] d;
        chk({tag, " level"}, 32'(irq_level), 32'(exp_level()));
        chk({tag, " vector"}, 32'(irq_vector), 32'(exp_vector()));
        rd(3'd0, d);
        chk({tag, " pending"}, d, 32'(m_pend));
    endtask

    task automatic do_ack(input logic [7:0] v);
        @(negedge clk);
        ack_valid = 1'b1; ack_vector = v;
        for (int i = 0; i < N; i++)
            if (8'(m_vbase + 8'(i)) == v) m_pend[i] = 1'b0;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int unsigned seed_val;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 level", 32'(irq_level), 0);
        chk("R10 vector", 32'(irq_vector), 0);
        rd(3'd0, d); chk("R10 pending", d, 0);
        rd(3'd1, d); chk("R10 enable", d, 0);
        rd(3'd2, d); chk("R10 edge", d, 32'hF);
        rd(3'd3, d); chk("R10 levels", d, 0);
        rd(3'd4, d); chk("R10 vbase", d, 0);
        rd(3'd7, d); chk("R11 unmapped", d, 0);

        // R11 readback; in0=2, in1=5, in2=5, in3=0
        wr(3'd4, 32'h40);
        wr(3'd3, 32'h16A);
        rd(3'd3, d); chk("R11 levels", d, 32'h16A);
        rd(3'd4, d); chk("R11 vbase", d, 32'h40);

        // R2 latched while disabled, single-clock pulse
        @(negedge clk); irq_pin[0] = 1'b1; m_pend[0] = 1'b1;
        @(negedge clk); irq_pin[0] = 1'b0;
        settle();
        chk_out("R2 masked pulse");
        // R5 enabling presents it
        wr(3'd1, 32'hF);
        settle();
        chk_out("R5 enable");
        chk("R5 level", 32'(irq_level), 2);

        // R7 tie at level 5: index 1 beats index 2, R8 vector 0x41
        toggle(4'b0110);
        settle();
        chk_out("R7 tie");
        chk("R8 vector", 32'(irq_vector), 32'h41);

        // R9 acknowledge drops level next cycle and clears input 1
        @(negedge clk);
        ack_valid = 1'b1; ack_vector = irq_vector; m_pend[1] = 1'b0;
        @(negedge clk);
        ack_valid = 1'b0;
        chk("R9 drop", 32'(irq_level), 0);
        settle();
        chk_out("R9 after ack");
        chk("R9 next vector", 32'(irq_vector), 32'h42);

        // R3 write-one clear, write zero has no effect
        wr(3'd0, 32'h4);
        settle();
        chk_out("R3 w1c");
        wr(3'd0, 32'h0);
        settle();
        chk_out("R3 write zero");

        // R6 level 0 input never presented
        toggle(4'b1000);
        settle();
        chk_out("R6 level0 hidden");
        wr(3'd0, 32'h1);
        settle();
        chk_out("R6 only level0 left");
        chk("R6 level", 32'(irq_level), 0);
        wr(3'd0, 32'hF);

        // R12 polarity change with pin1 high gives no event
        wr(3'd2, 32'hD);
        settle();
        chk_out("R12 no event");
        // R1 falling edge on pin1 latches, later rising does not
        toggle(4'b0010);
        settle();
        chk_out("R1 falling");
        wr(3'd0, 32'h2);
        toggle(4'b0010);
        settle();
        chk_out("R1 rising ignored");

        // R4 new edge in the same cycle as its clear
        toggle(4'b0001);
        toggle(4'b0001);
        settle();
        @(negedge clk); irq_pin[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h1;
        @(negedge clk); reg_wr = 1'b0;
        @(negedge clk); irq_pin[0] = 1'b0;
        settle();
        rd(3'd0, d);
        chk("R4 race keeps bit", 32'(d[0]), 1);
        m_pend[0] = 1'b1;

        // random phase
        seed_val = $urandom(32'd1357);
        for (int it = 0; it < 80; it++) begin
            int op;
            op = int'($urandom_range(0, 6));
            case (op)
                0: toggle(4'($urandom));
                1: wr(3'd1, 32'($urandom_range(0, 15)));
                2: wr(3'd3, 32'($urandom) & 32'hFFF);
                3: wr(3'd2, 32'($urandom_range(0, 15)));
                4: wr(3'd0, 32'($urandom_range(0, 15)));
                5: if (irq_level != 0) do_ack(irq_vector); else toggle(4'($urandom));
                default: wr(3'd4, 32'($urandom_range(240, 255)));
            endcase
            settle();
            chk_out("R7 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule